// File: doc/BRIEF.md
# Double-Buffered Serial Byte Path

This block is the register core of an asynchronous serial port. Outgoing bytes pass through a CPU-visible transmit holding register into a hidden shift register that drives `txd`. Incoming bits on `rxd` collect in a hidden shift register, and each complete byte moves into a CPU-visible receive holding register. Because each direction has a holding register as well as a shift register, the CPU can queue the next outgoing byte while the current one is still on the line. The shift register can also take in the next incoming byte while software has not yet read the last one.

Bit timing comes from outside the block. `txTick` and `rxTick` are single-cycle strobes, one per bit time. Framing, parity and baud generation belong to the surrounding logic. A `txEmpty` flag shows when the transmit holding register may be refilled. `rxFull` and `rxOverrun` report receive status. A standby input returns all data registers to their initial values.

Top module: `serial_dbuf_core`

## Requirements
- R1: After reset, reading the transmit register (cpuAddr=0) returns 0xFF and reading the receive register (cpuAddr=1) returns 0x00. `txEmpty` is 1, `rxFull` and `rxOverrun` are 0, and `txd` is 1.
- R2: A write with cpuWe=1 and cpuAddr=0 stores cpuWdata in the transmit register, which reads back from the next cycle on, and clears `txEmpty`. A write with cpuAddr=1 has no effect on the receive register.
- R3: While the shifter is idle and `txEmpty` is 0, the next `txTick` copies the transmit register into the shifter and sets `txEmpty` to 1. Bit 0 of that byte appears on `txd` in the cycle after that tick.
- R4: Bits leave least significant first. Each bit stays on `txd` until the next `txTick`. If `txEmpty` is 0 on the tick that ends bit 7, the next byte's bit 0 follows on that same tick with no idle gap.
- R5: If `txEmpty` is 1 on the tick that ends bit 7, the shifter stops and `txd` returns to 1.
- R6: `txd` is 1 whenever the transmit shifter holds no byte.
- R7: Each `rxTick` samples `rxd` into the receive shifter, least significant bit first. On the eighth sample the byte is copied into the receive register and `rxFull` is set.
- R8: A read with cpuRe=1 and cpuAddr=1 clears `rxFull` and `rxOverrun` in the following cycle, unless a byte completes in that same cycle.
- R9: A byte that completes while `rxFull` is 1 replaces the receive register and sets `rxOverrun`.
- R10: While `standby` is 1, the transmit register is forced to 0xFF and the receive register to 0x00. `txEmpty` goes to 1, `rxFull` and `rxOverrun` go to 0, both shifters are abandoned with `txd` at 1, and CPU writes are ignored.
- R11: When a CPU write and a transmit load fall in the same cycle, the shifter takes the old register contents. The register takes the new data, and `txEmpty` ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous standby: forces initial values |
| txTick | input | 1 | One-cycle strobe per transmit bit time |
| rxTick | input | 1 | One-cycle strobe per receive bit time |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data, idles high |
| cpuAddr | input | 1 | Register select: 0 transmit, 1 receive |
| cpuWe | input | 1 | CPU write strobe |
| cpuRe | input | 1 | CPU read strobe (read side effects) |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | Selected register contents |
| txEmpty | output | 1 | Transmit register may be refilled |
| rxFull | output | 1 | Unread byte in receive register |
| rxOverrun | output | 1 | A byte was overwritten before being read |

## Verification
The hardest case to reach from the ports is the back-to-back handover. The next byte has to be written after the current byte was loaded and before the tick that ends its bit 7, and there is also the variant where that write lands in the same cycle as a load. The stimulus mixes random gaps between ticks with a random choice, taken just before each final tick, to queue another byte or let the line go idle. A directed step lines up a write exactly on a load edge. Overrun is produced by receiving two bytes with no read in between.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef struct packed {
    logic forceInit;
    logic txWrite;
    logic txLoad;
    logic txShift;
    logic rxShift;
    logic rxCommit;
  } sdbStrobes_t;
endpackage

// File: rtl/sdb_ctrl.sv
module sdb_ctrl
  import sdb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        standby,
  input  logic        txTick,
  input  logic        rxTick,
  input  logic        cpuAddr,
  input  logic        cpuWe,
  input  logic        cpuRe,
  output sdbStrobes_t strobes,
  output logic        txActive,
  output logic        txEmpty,
  output logic        rxFull,
  output logic        rxOverrun
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] rxCnt;
  logic wrTx, rdRx, lastTxBit, txStop;

  always_comb begin
    wrTx      = cpuWe && !cpuAddr && !standby;
    rdRx      = cpuRe && cpuAddr && !standby;
    lastTxBit = txActive && (txCnt == LAST_BIT);
    txStop    = !standby && txTick && lastTxBit && txEmpty;

    strobes.forceInit = standby;
    strobes.txWrite   = wrTx;
    strobes.txLoad    = !standby && txTick && !txEmpty && (!txActive || lastTxBit);
    strobes.txShift   = !standby && txTick && txActive && !lastTxBit;
    strobes.rxShift   = !standby && rxTick;
    strobes.rxCommit  = !standby && rxTick && (rxCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive  <= 1'b0;
      txEmpty   <= 1'b1;
      txCnt     <= '0;
      rxCnt     <= '0;
      rxFull    <= 1'b0;
      rxOverrun <= 1'b0;
    end else if (standby) begin
      txActive  <= 1'b0;
      txEmpty   <= 1'b1;
      txCnt     <= '0;
      rxCnt     <= '0;
      rxFull    <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      if (wrTx)                txEmpty <= 1'b0;
      else if (strobes.txLoad) txEmpty <= 1'b1;

      if (strobes.txLoad)      txActive <= 1'b1;
      else if (txStop)         txActive <= 1'b0;

      if (strobes.txLoad)       txCnt <= '0;
      else if (strobes.txShift) txCnt <= txCnt + 1'b1;

      if (strobes.rxShift)
        rxCnt <= strobes.rxCommit ? '0 : rxCnt + 1'b1;

      if (strobes.rxCommit)    rxFull <= 1'b1;
      else if (rdRx)           rxFull <= 1'b0;

      if (strobes.rxCommit && rxFull) rxOverrun <= 1'b1;
      else if (rdRx && !strobes.rxCommit) rxOverrun <= 1'b0;
    end
  end
endmodule

// File: rtl/sdb_datapath.sv
module sdb_datapath
  import sdb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdbStrobes_t       strobes,
  input  logic              txActive,
  input  logic              rxd,
  input  logic              cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              txd
);
  localparam logic [DATA_W-1:0] TX_INIT = '1;
  localparam logic [DATA_W-1:0] RX_INIT = '0;

  logic [DATA_W-1:0] txBuf, txSh, rxSh, rxBuf;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {rxd, rxSh[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf <= TX_INIT;
      txSh  <= TX_INIT;
      rxSh  <= RX_INIT;
      rxBuf <= RX_INIT;
    end else if (strobes.forceInit) begin
      txBuf <= TX_INIT;
      txSh  <= TX_INIT;
      rxSh  <= RX_INIT;
      rxBuf <= RX_INIT;
    end else begin
      if (strobes.txWrite) txBuf <= cpuWdata;

      if (strobes.txLoad)       txSh <= txBuf;
      else if (strobes.txShift) txSh <= {1'b1, txSh[DATA_W-1:1]};

      if (strobes.rxShift)  rxSh  <= rxNext;
      if (strobes.rxCommit) rxBuf <= rxNext;
    end
  end

  always_comb begin
    cpuRdata = cpuAddr ? rxBuf : txBuf;
    txd      = txActive ? txSh[0] : 1'b1;
  end
endmodule

// File: rtl/serial_dbuf_core.sv
module serial_dbuf_core
  import sdb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              txTick,
  input  logic              rxTick,
  input  logic              rxd,
  output logic              txd,
  input  logic              cpuAddr,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxOverrun
);
  sdbStrobes_t strobes;
  logic        txActive;

  sdb_ctrl #(.DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .standby(standby),
    .txTick(txTick), .rxTick(rxTick),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuRe(cpuRe),
    .strobes(strobes), .txActive(txActive),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxOverrun(rxOverrun)
  );

  sdb_datapath #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txActive(txActive),
    .rxd(rxd), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .txd(txd)
  );
endmodule

// File: rtl/sdb_checker.sv
module sdb_checker (
  input logic clk,
  input logic rstN,
  input logic standby,
  input logic txTick,
  input logic rxTick,
  input logic cpuAddr,
  input logic cpuWe,
  input logic cpuRe,
  input logic txd,
  input logic txEmpty,
  input logic rxFull,
  input logic rxOverrun
);
  a_r2_write_clears_empty: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && !cpuAddr && !standby) |=> !txEmpty);

  a_r3_empty_sets_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> ($past(txTick) || $past(standby)));

  a_r4_txd_holds_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (!txTick && !standby) |=> $stable(txd));

  a_r7_full_rises_on_rx_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(rxTick));

  a_r8_read_clears_full: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRe && cpuAddr && !rxTick) |=> (!rxFull && !rxOverrun));

  a_r9_overrun_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxFull));

  a_r10_standby_forces: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (txEmpty && !rxFull && !rxOverrun && txd));
endmodule

bind serial_dbuf_core sdb_checker sdbChk (
  .clk(clk), .rstN(rstN), .standby(standby), .txTick(txTick), .rxTick(rxTick),
  .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuRe(cpuRe), .txd(txd),
  .txEmpty(txEmpty), .rxFull(rxFull), .rxOverrun(rxOverrun)
);

// File: tb/serial_dbuf_core_test.sv
`timescale 1ns/1ps
module serial_dbuf_core_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standby = 1'b0, txTick = 1'b0, rxTick = 1'b0, rxd = 1'b1;
  logic cpuAddr = 1'b0, cpuWe = 1'b0, cpuRe = 1'b0;
  logic [7:0] cpuWdata = 8'h00;
  logic [7:0] cpuRdata;
  logic txd, txEmpty, rxFull, rxOverrun;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_dbuf_core uut (
    .clk(clk), .rstN(rstN), .standby(standby), .txTick(txTick), .rxTick(rxTick),
    .rxd(rxd), .txd(txd), .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuRe(cpuRe),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .txEmpty(txEmpty),
    .rxFull(rxFull), .rxOverrun(rxOverrun)
  );

  function automatic logic expBit(logic [7:0] b, int i);
    return b[i];
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(logic a, logic [7:0] d);
    cpuAddr = a; cpuWdata = d; cpuWe = 1'b1;
    @(negedge clk);
    cpuWe = 1'b0; cpuAddr = 1'b0;
  endtask

  task automatic peek(logic a, output logic [7:0] d);
    cpuAddr = a; #1; d = cpuRdata; cpuAddr = 1'b0;
  endtask

  task automatic readRx(output logic [7:0] d);
    cpuAddr = 1'b1; cpuRe = 1'b1; #1; d = cpuRdata;
    @(negedge clk);
    cpuRe = 1'b0; cpuAddr = 1'b0;
  endtask

  // random idle gap, txd must not move, then one tick
  task automatic txPulse();
    logic held;
    int gap;
    held = txd;
    gap = $urandom % 4;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R4 hold", txd, held);
    end
    txTick = 1'b1;
    @(negedge clk);
    txTick = 1'b0;
  endtask

  task automatic rxByte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; rxTick = 1'b1;
      @(negedge clk);
      rxTick = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, b, nb;
    bit running;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(1'b0, d); chk("R1 txbuf", d, 8'hFF);
    peek(1'b1, d); chk("R1 rxbuf", d, 8'h00);
    chk("R1 txEmpty", txEmpty, 1); chk("R1 rxFull", rxFull, 0);
    chk("R1 overrun", rxOverrun, 0); chk("R1 txd", txd, 1);

    // R6 idle ticks with empty buffer keep line high
    txPulse(); chk("R6 idle txd", txd, 1);

    // R2 write/readback, write to receive address ignored
    cpuWrite(1'b0, 8'h3C);
    peek(1'b0, d); chk("R2 readback", d, 8'h3C);
    chk("R2 txEmpty", txEmpty, 0);
    cpuWrite(1'b1, 8'h55);
    peek(1'b1, d); chk("R2 rx write ignored", d, 8'h00);

    // R3/R4/R5 single byte
    txPulse();
    chk("R3 first bit", txd, expBit(8'h3C, 0)); chk("R3 txEmpty", txEmpty, 1);
    for (int i = 1; i < 8; i++) begin
      txPulse(); chk("R4 bit", txd, expBit(8'h3C, i));
    end
    txPulse(); chk("R5 stop", txd, 1);
    txPulse(); chk("R6 idle", txd, 1);

    // R4/R5 random stream with random queueing decisions
    running = 0;
    b = 8'($urandom);
    cpuWrite(1'b0, b);
    for (int k = 0; k < 24; k++) begin
      if (!running) begin
        txPulse();
        chk("R3 load bit0", txd, expBit(b, 0)); chk("R3 empty set", txEmpty, 1);
      end
      for (int i = 1; i < 8; i++) begin
        txPulse(); chk("R4 bit", txd, expBit(b, i));
      end
      if (($urandom % 3) != 0) begin
        nb = 8'($urandom);
        cpuWrite(1'b0, nb);
        txPulse();
        chk("R4 back-to-back", txd, expBit(nb, 0)); chk("R4 empty", txEmpty, 1);
        b = nb; running = 1;
      end else begin
        txPulse(); chk("R5 stop", txd, 1);
        txPulse(); chk("R6 idle", txd, 1);
        b = 8'($urandom);
        cpuWrite(1'b0, b);
        running = 0;
      end
    end
    // drain the pending byte
    if (!running) begin
      txPulse(); chk("R3 load bit0", txd, expBit(b, 0));
    end
    for (int i = 1; i < 8; i++) begin
      txPulse(); chk("R4 bit", txd, expBit(b, i));
    end
    txPulse(); chk("R5 stop", txd, 1);

    // R11 write on the same edge as a load
    cpuWrite(1'b0, 8'hA5);
    cpuAddr = 1'b0; cpuWdata = 8'h5A; cpuWe = 1'b1; txTick = 1'b1;
    @(negedge clk);
    cpuWe = 1'b0; txTick = 1'b0;
    chk("R11 shifter old data", txd, expBit(8'hA5, 0));
    chk("R11 txEmpty", txEmpty, 0);
    peek(1'b0, d); chk("R11 buffer new", d, 8'h5A);
    for (int i = 1; i < 8; i++) begin
      txPulse(); chk("R11 old bits", txd, expBit(8'hA5, i));
    end
    txPulse(); chk("R11 next byte", txd, expBit(8'h5A, 0));

    // R10 standby mid-transmission
    standby = 1'b1;
    cpuWrite(1'b0, 8'h12);
    standby = 1'b0;
    peek(1'b0, d); chk("R10 txbuf", d, 8'hFF);
    chk("R10 txd", txd, 1); chk("R10 txEmpty", txEmpty, 1);
    txPulse(); chk("R10 stays idle", txd, 1);

    // R7/R8 random receive
    for (int k = 0; k < 12; k++) begin
      b = 8'($urandom);
      rxByte(b);
      chk("R7 full", rxFull, 1);
      readRx(d); chk("R7 data", d, b);
      chk("R8 cleared", rxFull, 0);
    end

    // R9 overrun, then R8 clears it
    rxByte(8'h81);
    rxByte(8'h7E);
    chk("R9 overrun", rxOverrun, 1);
    peek(1'b1, d); chk("R9 overwritten", d, 8'h7E);
    readRx(d);
    chk("R8 overrun cleared", rxOverrun, 0); chk("R8 full cleared", rxFull, 0);

    // R10 standby clears receive side and partial byte
    rxByte(8'hC3);
    for (int i = 0; i < 3; i++) begin
      rxd = 1'b1; rxTick = 1'b1; @(negedge clk); rxTick = 1'b0;
    end
    standby = 1'b1; @(negedge clk); standby = 1'b0;
    peek(1'b1, d); chk("R10 rxbuf", d, 8'h00);
    chk("R10 rxFull", rxFull, 0);
    rxByte(8'h96);
    peek(1'b1, d); chk("R10 fresh byte", d, 8'h96);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule